// File: doc/BRIEF.md
# Synthesizer Configuration Register Interface

This block keeps the configuration word of a clock synthesizer: a 7-bit loop feedback divider value, a 2-bit output post-divider code and a 3-bit test-output selector. The word can be written over two independent paths, each with its own capture rule.

The first path is a three-wire serial port: a shift clock, a data line and a load strobe. Data bits enter a 12-bit shift register on each rising shift-clock edge. The register contents are committed on each falling edge of the load strobe. The second path is a 9-bit parallel bus carrying the feedback and post-divider values. It is captured on the rising edge of its own strobe and always wins over the serial path.

The shift clock and both strobes come from outside the block's clock domain. Each passes through a synchronizer chain before its edges are detected on the system clock. The block also decodes the test selector into a one-hot select, and it flags a feedback value whose resulting oscillator frequency falls outside the legal window. That window is the parameterized reference frequency times the feedback value, checked against 400 to 900 MHz.

Top module: `synth_cfg_regs`

## Requirements
- R1: While reset is active and after it is released, the feedback value is 7'h7F, the post-divider code is 2'b11 and the test selector is 3'b000, until a load occurs.
- R2: Each rising edge of the serial clock shifts the data line into bit 0 of the 12-bit shift register and moves the older bits up. The bits are sent test selector first, then post-divider, then feedback, each MSB first. A falling edge of the serial load strobe, with the parallel strobe high, commits bits [11:9] as test selector, [8:7] as post-divider and [6:0] as feedback.
- R3: A rising edge of the parallel strobe captures the feedback value from the parallel bus bits [6:0] and the post-divider code from bits [8:7]. The test selector is left unchanged.
- R4: While the synchronized parallel strobe is low, a falling edge of the serial load strobe changes no output.
- R5: When a parallel rising edge and a serial load falling edge are detected in the same cycle, feedback and post-divider take the parallel values and the test selector keeps its old value.
- R6: With two synchronizer stages, a strobe edge applied between two clock edges shows at the outputs after the third following rising clock edge and not after the second.
- R7: Shifting serial bits without a falling load edge leaves every output unchanged.
- R8: The one-hot test select output has exactly one bit set, at the index given by the test selector.
- R9: The range flag is high exactly when feedback times REF_MHZ is below 400 or above 900, and both limits are legal. With REF_MHZ = 16, feedback values 25 and 56 are in range while 20 and 57 are not.
- R10: A falling edge of the parallel strobe and a rising edge of the serial load strobe change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, held stable around shift-clock rises |
| ser_ld_i | input | 1 | Serial commit strobe, acts on its falling edge |
| par_ld_i | input | 1 | Parallel capture strobe, acts on its rising edge |
| par_m_i | input | 7 | Parallel feedback divider value |
| par_n_i | input | 2 | Parallel post-divider code |
| fb_div_o | output | 7 | Latched feedback divider value |
| post_div_o | output | 2 | Latched post-divider code |
| test_sel_o | output | 3 | Latched test selector |
| test_oh_o | output | 8 | One-hot decode of the test selector |
| vco_err_o | output | 1 | Oscillator frequency outside 400 to 900 MHz |

## Verification
Every strobe and serial-clock result is due at the third rising clock edge after the input changes. That is two synchronizer flops plus the edge register, with the capture in the same edge. The bench drives inputs at the falling clock edge and counts exactly three rising edges before it samples, one time unit after the edge. The latency test also samples after the second edge to confirm the old value is still there. The one-hot select and range flag follow the latched values combinationally, so they are checked in the same sample as the registers they decode.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   localparam int FB_W    = 7;
   localparam int PD_W    = 2;
   localparam int TS_W    = 3;
   localparam int WORD_W  = TS_W + PD_W + FB_W;
   localparam int PAR_W   = PD_W + FB_W;
   localparam int TOH_W   = 1 << TS_W;

   typedef struct packed {
      logic [TS_W-1:0] tsel;
      logic [PD_W-1:0] pdiv;
      logic [FB_W-1:0] fbdiv;
   } cfg_word_t;

   localparam cfg_word_t CFG_RESET = '{tsel: '0, pdiv: '1, fbdiv: '1};
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= async_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= 1'b0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;
   assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
   parameter int WIDTH = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_i,
   input  logic             din_i,
   output logic [WIDTH-1:0] word_o
);
   if (WIDTH < 2) begin : g_bad_width
      $error("cfg_shift_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (shift_i) sr_q <= {sr_q[WIDTH-2:0], din_i};
   end

   assign word_o = sr_q;
endmodule

// File: rtl/cfg_word_latch.sv
module cfg_word_latch
   import synth_cfg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_rise_i,
   input  logic             par_level_i,
   input  logic             ser_fall_i,
   input  logic [PAR_W-1:0] par_bus_i,
   input  cfg_word_t        ser_word_i,
   output cfg_word_t        cfg_o
);
   cfg_word_t cfg_q, cfg_d;
   logic      ser_take;

   // serial commit honoured only while the parallel strobe sits high
   assign ser_take = ser_fall_i & par_level_i & ~par_rise_i;

   always_comb begin
      cfg_d = cfg_q;
      if (par_rise_i) begin
         cfg_d.fbdiv = par_bus_i[FB_W-1:0];
         cfg_d.pdiv  = par_bus_i[PAR_W-1:FB_W];
      end else if (ser_take) begin
         cfg_d = ser_word_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= CFG_RESET;
      else        cfg_q <= cfg_d;
   end

   assign cfg_o = cfg_q;
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
   import synth_cfg_pkg::*;
#(
   parameter int REF_MHZ     = 16,
   parameter int VCO_MIN_MHZ = 400,
   parameter int VCO_MAX_MHZ = 900
) (
   input  logic [FB_W-1:0]  fbdiv_i,
   input  logic [TS_W-1:0]  tsel_i,
   output logic [TOH_W-1:0] test_oh_o,
   output logic             vco_err_o
);
   localparam int PROD_W = 32;

   for (genvar i = 0; i < TOH_W; i++) begin : g_oh
      assign test_oh_o[i] = (tsel_i == TS_W'(i));
   end

   logic [PROD_W-1:0] vco_mhz;
   assign vco_mhz   = PROD_W'(fbdiv_i) * PROD_W'(REF_MHZ);
   assign vco_err_o = (vco_mhz < PROD_W'(VCO_MIN_MHZ)) ||
                      (vco_mhz > PROD_W'(VCO_MAX_MHZ));
endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
   import synth_cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int REF_MHZ     = 16,
   parameter int VCO_MIN_MHZ = 400,
   parameter int VCO_MAX_MHZ = 900
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk_i,
   input  logic             ser_dat_i,
   input  logic             ser_ld_i,
   input  logic             par_ld_i,
   input  logic [FB_W-1:0]  par_m_i,
   input  logic [PD_W-1:0]  par_n_i,
   output logic [FB_W-1:0]  fb_div_o,
   output logic [PD_W-1:0]  post_div_o,
   output logic [TS_W-1:0]  test_sel_o,
   output logic [TOH_W-1:0] test_oh_o,
   output logic             vco_err_o
);
   localparam int N_SYNC = 3;
   localparam int IX_SCK = 0;
   localparam int IX_SLD = 1;
   localparam int IX_PLD = 2;

   if (REF_MHZ < 1 || VCO_MAX_MHZ < VCO_MIN_MHZ) begin : g_bad_range
      $error("synth_cfg_regs: illegal frequency parameters");
   end

   logic [N_SYNC-1:0] raw_in, lvl, rise, fall;
   assign raw_in = {par_ld_i, ser_ld_i, ser_clk_i};

   for (genvar k = 0; k < N_SYNC; k++) begin : g_sync
      cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (raw_in[k]),
         .level_o (lvl[k]),
         .rise_o  (rise[k]),
         .fall_o  (fall[k])
      );
   end

   logic            par_rise, par_level, ser_fall, sck_rise;
   logic [WORD_W-1:0] sr_word;
   cfg_word_t       cfg;

   assign par_rise  = rise[IX_PLD];
   assign par_level = lvl[IX_PLD];
   assign ser_fall  = fall[IX_SLD];
   assign sck_rise  = rise[IX_SCK];

   cfg_shift_reg #(.WIDTH(WORD_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (sck_rise),
      .din_i   (ser_dat_i),
      .word_o  (sr_word)
   );

   cfg_word_latch u_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .par_rise_i  (par_rise),
      .par_level_i (par_level),
      .ser_fall_i  (ser_fall),
      .par_bus_i   ({par_n_i, par_m_i}),
      .ser_word_i  (cfg_word_t'(sr_word)),
      .cfg_o       (cfg)
   );

   cfg_decode #(
      .REF_MHZ     (REF_MHZ),
      .VCO_MIN_MHZ (VCO_MIN_MHZ),
      .VCO_MAX_MHZ (VCO_MAX_MHZ)
   ) u_dec (
      .fbdiv_i   (cfg.fbdiv),
      .tsel_i    (cfg.tsel),
      .test_oh_o (test_oh_o),
      .vco_err_o (vco_err_o)
   );

   assign fb_div_o   = cfg.fbdiv;
   assign post_div_o = cfg.pdiv;
   assign test_sel_o = cfg.tsel;
endmodule

// File: rtl/synth_cfg_regs_chk.sv
module synth_cfg_regs_chk
   import synth_cfg_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              par_rise,
   input logic              par_level,
   input logic              ser_fall,
   input logic [WORD_W-1:0] sr_word,
   input logic [FB_W-1:0]   par_m_i,
   input logic [PD_W-1:0]   par_n_i,
   input logic [FB_W-1:0]   fb_div_o,
   input logic [PD_W-1:0]   post_div_o,
   input logic [TS_W-1:0]   test_sel_o,
   input logic [TOH_W-1:0]  test_oh_o,
   input logic              vco_err_o
);
   assert_onehot_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(test_oh_o) == 1) && test_oh_o[test_sel_o]);

   assert_par_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      par_rise |=> (fb_div_o == $past(par_m_i)) && (post_div_o == $past(par_n_i))
                   && $stable(test_sel_o));

   assert_ser_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_fall && par_level && !par_rise) |=>
         ({test_sel_o, post_div_o, fb_div_o} == $past(sr_word)));

   assert_tie_keeps_tsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (par_rise && ser_fall) |=> $stable(test_sel_o));

   assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_rise && !(ser_fall && par_level)) |=>
         ($stable(fb_div_o) && $stable(post_div_o) && $stable(test_sel_o)));

   assert_flag_follows_fb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(fb_div_o) |-> $stable(vco_err_o));
endmodule

bind synth_cfg_regs synth_cfg_regs_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .par_rise   (par_rise),
   .par_level  (par_level),
   .ser_fall   (ser_fall),
   .sr_word    (sr_word),
   .par_m_i    (par_m_i),
   .par_n_i    (par_n_i),
   .fb_div_o   (fb_div_o),
   .post_div_o (post_div_o),
   .test_sel_o (test_sel_o),
   .test_oh_o  (test_oh_o),
   .vco_err_o  (vco_err_o)
);

// File: tb/tb_synth_cfg_regs.sv
`timescale 1ns/1ps
module tb_synth_cfg_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_ld_i = 1'b0, par_ld_i = 1'b0;
   logic [6:0] par_m_i = 7'h7F;
   logic [1:0] par_n_i = 2'b11;
   logic [6:0] fb_div_o;
   logic [1:0] post_div_o;
   logic [2:0] test_sel_o;
   logic [7:0] test_oh_o;
   logic       vco_err_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   synth_cfg_regs dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
      .ser_ld_i(ser_ld_i), .par_ld_i(par_ld_i), .par_m_i(par_m_i), .par_n_i(par_n_i),
      .fb_div_o(fb_div_o), .post_div_o(post_div_o), .test_sel_o(test_sel_o),
      .test_oh_o(test_oh_o), .vco_err_o(vco_err_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_cfg(input string req, input logic [6:0] m, input logic [1:0] n,
                          input logic [2:0] t);
      chk({fb_div_o, post_div_o, test_sel_o} == {m, n, t}, req,
          {20'd0, fb_div_o, post_div_o, test_sel_o}, {20'd0, m, n, t});
   endtask

   // wait n rising edges, then sample 1 ns later
   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drive_edge();
      @(negedge clk);
   endtask

   task automatic par_load(input logic [6:0] m, input logic [1:0] n);
      drive_edge();
      par_ld_i = 1'b0;
      edges(4);
      drive_edge();
      par_m_i = m; par_n_i = n; par_ld_i = 1'b1;
      edges(3);
   endtask

   task automatic send_bits(input logic [11:0] w);
      for (int i = 11; i >= 0; i--) begin
         drive_edge();
         ser_dat_i = w[i];
         ser_clk_i = 1'b1;
         edges(3);
         drive_edge();
         ser_clk_i = 1'b0;
         edges(3);
      end
   endtask

   task automatic ser_commit();
      drive_edge();
      ser_ld_i = 1'b1;
      edges(4);
      drive_edge();
      ser_ld_i = 1'b0;
      edges(3);
   endtask

   task automatic t_reset();
      chk_cfg("R1 reset value", 7'h7F, 2'b11, 3'b000);
      chk(test_oh_o == 8'h01, "R8 reset one-hot", {24'd0, test_oh_o}, 32'h01);
      chk(vco_err_o == 1'b1, "R9 reset 127x16 out of range", {31'd0, vco_err_o}, 32'd1);
   endtask

   task automatic t_parallel();
      par_load(7'd40, 2'b01);
      chk_cfg("R3 parallel capture", 7'd40, 2'b01, 3'b000);
      chk(vco_err_o == 1'b0, "R9 40x16 in range", {31'd0, vco_err_o}, 32'd0);
   endtask

   task automatic t_latency();
      drive_edge();
      par_ld_i = 1'b0;
      edges(4);
      drive_edge();
      par_m_i = 7'd56; par_n_i = 2'b00; par_ld_i = 1'b1;
      edges(2);
      chk_cfg("R6 not yet after second edge", 7'd40, 2'b01, 3'b000);
      edges(1);
      chk_cfg("R6 due after third edge", 7'd56, 2'b00, 3'b000);
      chk(vco_err_o == 1'b0, "R9 upper boundary 56", {31'd0, vco_err_o}, 32'd0);
   endtask

   task automatic t_serial();
      // T=5, N=2, M=25
      send_bits({3'd5, 2'b10, 7'd25});
      chk_cfg("R7 shifting leaves outputs", 7'd56, 2'b00, 3'b000);
      drive_edge();
      ser_ld_i = 1'b1;
      edges(4);
      chk_cfg("R10 serial strobe rise ignored", 7'd56, 2'b00, 3'b000);
      drive_edge();
      ser_ld_i = 1'b0;
      edges(3);
      chk_cfg("R2 serial commit", 7'd25, 2'b10, 3'd5);
      chk(test_oh_o == 8'h20, "R8 one-hot index 5", {24'd0, test_oh_o}, 32'h20);
      chk(vco_err_o == 1'b0, "R9 lower boundary 25", {31'd0, vco_err_o}, 32'd0);
   endtask

   task automatic t_ignore_when_par_low();
      drive_edge();
      par_m_i = 7'd1; par_n_i = 2'b01;
      par_ld_i = 1'b0;
      edges(4);
      chk_cfg("R10 parallel fall ignored", 7'd25, 2'b10, 3'd5);
      send_bits({3'd2, 2'b01, 7'd20});
      ser_commit();
      chk_cfg("R4 serial load blocked", 7'd25, 2'b10, 3'd5);
   endtask

   task automatic t_tie();
      // shift register holds T=2,N=1,M=20; par low, ser_ld raised first
      drive_edge();
      ser_ld_i = 1'b1;
      edges(4);
      drive_edge();
      par_m_i = 7'd57; par_n_i = 2'b11;
      par_ld_i = 1'b1; ser_ld_i = 1'b0;
      edges(3);
      chk_cfg("R5 coincident parallel wins", 7'd57, 2'b11, 3'd5);
      chk(vco_err_o == 1'b1, "R9 57 above range", {31'd0, vco_err_o}, 32'd1);
   endtask

   task automatic t_serial_low_fb();
      ser_commit();
      chk_cfg("R2 second serial commit", 7'd20, 2'b01, 3'd2);
      chk(test_oh_o == 8'h04, "R8 one-hot index 2", {24'd0, test_oh_o}, 32'h04);
      chk(vco_err_o == 1'b1, "R9 20 below range", {31'd0, vco_err_o}, 32'd1);
   endtask

   initial begin
      edges(3);
      t_reset();
      drive_edge();
      rst_n = 1'b1;
      edges(3);
      chk_cfg("R1 after release", 7'h7F, 2'b11, 3'b000);
      t_parallel();
      t_latency();
      t_serial();
      t_ignore_when_par_low();
      t_tie();
      t_serial_low_fb();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule